// File: doc/BRIEF.md
# Trailing 1-1-0 Serial Pattern Detector (Mealy and Moore Pair)

This block watches a one-bit serial stream that is sampled on every rising clock edge. It raises a flag whenever the most recent bits are 1, 1 and then 0, with the 0 being the newest bit. Any run of two or more ones followed by a zero counts as one occurrence. No leading zero is needed, and a long run of ones does not produce more than one flag.

Two recognisers sit side by side. They share the clock, the reset and the data input, and each drives its own output pin. The first recogniser uses three states, and its flag is a combinational function of its state and the present input. The flag is therefore high during the same cycle in which the trailing 0 is presented. The second recogniser uses four states, and its flag is one of its state flops. That flag rises one clock later, and it cannot glitch when the input toggles. Instantiating both lets a designer compare the two timing styles on the same stream.

Top module: `seq110_detect_top`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge puts both recognisers in their idle state. In the cycle that follows, both flags are 0, and the pattern history is cleared. Any state code outside the legal set moves to idle on the next edge.
- R2: `hit_mealy` is 1 in a cycle where `din` is 0 and the two previous sampled bits since the last reset were both 1. Otherwise it is 0.
- R3: A run of any length of two or more ones followed by a 0 raises `hit_mealy` exactly once, in the cycle of the 0.
- R4: A single 1 between zeros, or a 0 that follows a 0, never raises either flag. A sampled 0 always returns the three-state recogniser to idle.
- R5: `hit_moore` depends on state alone. It stays constant for the whole cycle even while `din` toggles within that cycle.
- R6: `hit_moore` is high for one cycle only. From its flagged state, a 1 needs one more 1 before a 0 can flag again, and a 0 goes to idle.
- R7: On any stream, `hit_moore` in a cycle equals the value that `hit_mealy` had in the previous cycle, provided no reset was sampled at the edge between them.
- R8: `hit_mealy` is never 1 while `din` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit, sampled each rising edge |
| hit_mealy | output | 1 | Combinational flag, high in the cycle of the trailing 0 |
| hit_moore | output | 1 | Registered flag, high in the cycle after the trailing 0 |

## Verification
The bench targets runs of ones of different lengths ending in a zero. A recogniser that counts ones rather than saturating would flag only the first run, or would flag a run more than once. It also targets a pattern restart straight out of the flagged Moore state. A Moore machine that goes from its flagged state to the "one 1 seen" state on a 0, or to the "two 1s seen" state on a 1, would flag too early. Mid-cycle input toggles expose any leakage of `din` into the registered flag. A reset applied between two ones and a zero exposes history that survives reset.

// File: rtl/seq110_pkg.sv
package seq110_pkg;

    localparam int MEALY_W = 2;
    localparam int MOORE_W = 3;
    // position of the flag bit inside the Moore state code
    localparam int MOORE_FLAG_BIT = MOORE_W - 1;

    typedef enum logic [MEALY_W-1:0] {
        MLY_IDLE = 2'b00,
        MLY_ONE  = 2'b01,
        MLY_TWO  = 2'b10
    } mealy_st_e;

    typedef enum logic [MOORE_W-1:0] {
        MOR_IDLE = 3'b000,
        MOR_ONE  = 3'b001,
        MOR_TWO  = 3'b010,
        MOR_HIT  = 3'b100
    } moore_st_e;

    function automatic mealy_st_e mealy_next(input mealy_st_e cur, input logic bit_in);
        mealy_st_e nxt;
        nxt = MLY_IDLE;
        if (bit_in) begin
            case (cur)
                MLY_IDLE: nxt = MLY_ONE;
                MLY_ONE:  nxt = MLY_TWO;
                MLY_TWO:  nxt = MLY_TWO;
                default:  nxt = MLY_IDLE;
            endcase
        end
        return nxt;
    endfunction

    function automatic moore_st_e moore_next(input moore_st_e cur, input logic bit_in);
        moore_st_e nxt;
        nxt = MOR_IDLE;
        case (cur)
            MOR_IDLE: nxt = bit_in ? MOR_ONE : MOR_IDLE;
            MOR_ONE:  nxt = bit_in ? MOR_TWO : MOR_IDLE;
            MOR_TWO:  nxt = bit_in ? MOR_TWO : MOR_HIT;
            MOR_HIT:  nxt = bit_in ? MOR_ONE : MOR_IDLE;
            default:  nxt = MOR_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/seq110_mealy.sv
module seq110_mealy
    import seq110_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit
);

    mealy_st_e state_q;
    mealy_st_e state_d;

    always_comb begin
        state_d = mealy_next(state_q, din);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MLY_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        hit = (state_q == MLY_TWO) && !din;
    end

    AST_MEALY_RESET_IDLE: assert property (@(posedge clk) rst |=> state_q == MLY_IDLE); // R1
    AST_MEALY_BAD_CODE: assert property (@(posedge clk) disable iff (rst)
        !(state_q inside {MLY_IDLE, MLY_ONE, MLY_TWO}) |=> state_q == MLY_IDLE); // R1
    AST_MEALY_ZERO_IDLES: assert property (@(posedge clk) disable iff (rst)
        !din |=> state_q == MLY_IDLE); // R4
    AST_MEALY_TWO_AFTER_ONES: assert property (@(posedge clk) disable iff (rst)
        (state_q == MLY_TWO) |-> $past(din)); // R2

endmodule

// File: rtl/seq110_moore.sv
module seq110_moore
    import seq110_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit
);

    moore_st_e state_q;
    moore_st_e state_d;

    always_comb begin
        state_d = moore_next(state_q, din);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MOR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // flag taken straight from a state flop
    assign hit = state_q[MOORE_FLAG_BIT];

    AST_MOORE_RESET_IDLE: assert property (@(posedge clk) rst |=> state_q == MOR_IDLE); // R1
    AST_MOORE_BAD_CODE: assert property (@(posedge clk) disable iff (rst)
        !(state_q inside {MOR_IDLE, MOR_ONE, MOR_TWO, MOR_HIT}) |=> state_q == MOR_IDLE); // R1
    AST_MOORE_HIT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        hit |-> ($past(state_q) == MOR_TWO) && !$past(din)); // R5
    AST_MOORE_HIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit); // R6
    AST_MOORE_HIT_THEN_ONE: assert property (@(posedge clk) disable iff (rst)
        (hit && din) |=> state_q == MOR_ONE); // R6

endmodule

// File: rtl/seq110_detect_top.sv
module seq110_detect_top
    import seq110_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit_mealy,
    output logic hit_moore
);

    seq110_mealy u_mealy (
        .clk (clk),
        .rst (rst),
        .din (din),
        .hit (hit_mealy)
    );

    seq110_moore u_moore (
        .clk (clk),
        .rst (rst),
        .din (din),
        .hit (hit_moore)
    );

    AST_MOORE_LAGS_MEALY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> hit_moore == $past(hit_mealy)); // R7
    AST_MEALY_ONLY_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
        hit_mealy |-> !din); // R8

endmodule

// File: tb/seq110_detect_top_tb_top.sv
module seq110_detect_top_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic hit_mealy;
    logic hit_moore;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference history: h1 newest sampled bit, h2 the one before
    bit h1 = 1'b0;
    bit h2 = 1'b0;
    bit prev_match = 1'b0;

    always #10 clk = ~clk;

    seq110_detect_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .hit_mealy (hit_mealy),
        .hit_moore (hit_moore)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock cycle: drive bit b and reset level r, check, then let the edge sample
    task automatic step(input bit b, input bit r, input string tag);
        bit match;
        @(negedge clk);
        din = b;
        rst = r;
        #5;
        match = h1 && h2 && !b;
        check(tag, "hit_mealy", hit_mealy, match);
        check(tag, "hit_moore", hit_moore, prev_match);
        // R5: toggle din mid-cycle, registered flag must not move
        din = ~b;
        #2;
        check("R5", "hit_moore under din toggle", hit_moore, prev_match);
        if (din) check("R8", "hit_mealy with din=1", hit_mealy, 1'b0);
        din = b;
        if (r) begin
            h1 = 1'b0;
            h2 = 1'b0;
            prev_match = 1'b0;
        end else begin
            prev_match = match;
            h2 = h1;
            h1 = b;
        end
    endtask

    task automatic drive_str(input string s, input string tag);
        for (int i = 0; i < s.len(); i++) begin
            step(s[i] == "1", 1'b0, tag);
        end
    endtask

    initial begin
        step(1'b0, 1'b1, "R1");
        step(1'b1, 1'b1, "R1");
        // reset state visible at ports
        step(1'b0, 1'b0, "R1");
        // basic hit, Mealy in cycle of the 0, Moore one later
        drive_str("1100000", "R2");
        // long runs of ones end in one flag each
        drive_str("11110", "R3");
        drive_str("1111111100", "R3");
        // lone ones and double zeros never flag
        drive_str("0101010010", "R4");
        // restart from flagged Moore state
        drive_str("110110", "R6");
        drive_str("11010", "R6");
        drive_str("1101110", "R6");
        // reset between ones and the zero clears history
        drive_str("11", "R1");
        step(1'b1, 1'b1, "R1");
        drive_str("0000", "R1");
        // random streams, biased toward ones to form runs
        for (int seg = 0; seg < 4; seg++) begin
            for (int i = 0; i < 1500; i++) begin
                step(($urandom % (seg + 2)) != 0, 1'b0, "R7");
            end
            step($urandom % 2, 1'b1, "R1");
        end
        drive_str("000", "R7");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule